// File: doc/BRIEF.md
# DMA Request Source Router

This block sits between a large set of peripheral DMA request lines and the channels of a DMA engine. For every channel it holds one configuration byte. That byte says whether the channel listens to a peripheral at all, and if it does, which of up to 64 request lines it follows. Software programs the bytes through a byte-wide write port. A read port returns the programmed byte for the addressed channel.

The channels are split evenly between two identical routing groups. A channel's group is its index divided by the channels-per-group count. Its byte offset inside the group is the index modulo that count, so channel `g*CPG + o` is reached with group select `g` and offset `o`. In the configuration byte, bit 7 is the enable and bits 5:0 pick the source line. Bit 6 is reserved. Each channel's request output is that channel's selected peripheral line gated by the enable. A new setting steers the output from the first clock edge after the write.

Top module: `dreq_router`

## Requirements
- R1: While reset is held and directly after it is released, every configuration byte reads 0x00 and every channel request output is low, whatever the peripheral lines do.
- R2: After a write of a byte with bit 7 set and source s (bits 5:0), the channel's request output equals peripheral line s from the first clock edge after the write onward, and not in the cycle of the write.
- R3: A channel whose bit 7 is clear drives its request output low whatever its source field holds and whatever the peripheral lines do.
- R4: Writing 0x00 to an enabled channel turns its request output low from the next cycle onward.
- R5: Bit 6 of the configuration byte always reads back as 0; a write with bit 6 set stores the other seven bits and affects nothing else.
- R6: Reading a channel returns the enable in bit 7 and the source in bits 5:0, as last written.
- R7: A write with group select g and offset o changes only the configuration of channel g*CPG + o (CPG = channel count / 2); every other channel, including the same offset in the other group, keeps its configuration.
- R8: While the write strobe is low, no configuration byte changes, whatever the data, group and offset inputs do.
- R9: Several enabled channels may select the same peripheral line, and all of them then follow it at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; configuration is stored on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all configuration |
| cfg_wr | input | 1 | Write strobe for one configuration byte |
| cfg_grp | input | 1 | Routing group select, used for both writes and reads |
| cfg_off | input | 4 | Channel offset inside the selected group |
| cfg_wdata | input | 8 | Byte to write: bit 7 enable, bit 6 reserved, bits 5:0 source |
| cfg_rdata | output | 8 | Stored byte of the addressed channel (combinational) |
| src_req | input | 64 | Peripheral DMA request lines |
| ch_req | output | 32 | Per-channel request outputs to the DMA engine |

## Verification
On every cycle, the assertions check four things: a disabled channel drives its output low, an enabled channel mirrors its selected line, a hit entry loads the cleaned byte, and an entry that is not hit holds its value. They also confirm that a write to one group leaves the other group untouched and that bit 6 reads as zero. Some behaviour only the bench scenarios can show: the reset contents, the exact cycle in which a new setting takes hold, the mapping of group and offset to the flat channel index for every channel, and fan-out from one line to several channels. The bench checks all of these against its own model of the configuration bytes.

// File: rtl/dreq_router_pkg.sv
package dreq_router_pkg;

  // Configuration byte layout: the routing logic decodes these positions.
  localparam int EN_POS     = 7;
  localparam int RSVD_POS   = 6;
  localparam int SRC_W      = 6;
  localparam int NUM_GROUPS = 2;

  typedef logic [7:0]       cfg_byte_t;
  typedef logic [SRC_W-1:0] src_sel_t;

  // Byte as it is stored: the reserved bit is forced to zero.
  function automatic cfg_byte_t cfg_clean(input cfg_byte_t b);
    cfg_byte_t r;
    r           = b;
    r[RSVD_POS] = 1'b0;
    return r;
  endfunction

  function automatic logic cfg_enabled(input cfg_byte_t b);
    return b[EN_POS];
  endfunction

  function automatic src_sel_t cfg_source(input cfg_byte_t b);
    return b[SRC_W-1:0];
  endfunction

  // Flat channel index from group number and in-group offset.
  function automatic int flat_channel(input int grp, input int off, input int per_grp);
    return grp * per_grp + off;
  endfunction

endpackage

// File: rtl/dreq_cfg_bank.sv
module dreq_cfg_bank
  import dreq_router_pkg::*;
#(
  parameter int CH_PER_GRP = 16,
  localparam int AW = (CH_PER_GRP > 1) ? $clog2(CH_PER_GRP) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               addr,
  input  cfg_byte_t                   wdata,
  output cfg_byte_t                   rdata,
  output logic [CH_PER_GRP-1:0][7:0]  cfg_q
);

  logic [CH_PER_GRP-1:0] wr_hit;

  for (genvar i = 0; i < CH_PER_GRP; i++) begin : g_entry
    assign wr_hit[i] = wr_en && (addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q[i] <= '0;
      else if (wr_hit[i]) cfg_q[i] <= cfg_clean(wdata);
    end

    // R7: an addressed entry takes the written byte, reserved bit dropped
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> (cfg_q[i][7] == $past(wdata[7])) &&
                    (cfg_q[i][5:0] == $past(wdata[5:0])) && !cfg_q[i][6]);

    // R8: an entry that is not hit keeps its value
    p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[i] |=> $stable(cfg_q[i]));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < CH_PER_GRP; i++) begin
      if (addr == AW'(i)) rdata = cfg_q[i];
    end
  end

  p_one_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

endmodule

// File: rtl/dreq_route.sv
module dreq_route
  import dreq_router_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               en,
  input  src_sel_t           src_sel,
  input  logic [NUM_SRC-1:0] src_req,
  output logic               req_o
);

  logic sel_line;

  always_comb begin
    sel_line = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_sel == SRC_W'(s)) sel_line = src_req[s];
    end
  end

  assign req_o = en & sel_line;

endmodule

// File: rtl/dreq_group.sv
module dreq_group
  import dreq_router_pkg::*;
#(
  parameter int CH_PER_GRP = 16,
  parameter int NUM_SRC    = 64,
  localparam int AW = (CH_PER_GRP > 1) ? $clog2(CH_PER_GRP) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               addr,
  input  cfg_byte_t                   wdata,
  output cfg_byte_t                   rdata,
  input  logic [NUM_SRC-1:0]          src_req,
  output logic [CH_PER_GRP-1:0]       ch_req,
  output logic [CH_PER_GRP-1:0][7:0]  cfg_q
);

  dreq_cfg_bank #(.CH_PER_GRP(CH_PER_GRP)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .cfg_q (cfg_q)
  );

  for (genvar i = 0; i < CH_PER_GRP; i++) begin : g_ch
    logic     ch_en;
    src_sel_t ch_src;
    assign ch_en  = cfg_enabled(cfg_q[i]);
    assign ch_src = cfg_source(cfg_q[i]);

    dreq_route #(.NUM_SRC(NUM_SRC)) u_route (
      .en      (ch_en),
      .src_sel (ch_src),
      .src_req (src_req),
      .req_o   (ch_req[i])
    );

    // R3: disabled channel stays low
    p_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[i][7] |-> !ch_req[i]);

    // R2: enabled channel mirrors the selected line
    p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[i][7] && (int'(cfg_q[i][5:0]) < NUM_SRC))
        |-> (ch_req[i] == src_req[cfg_q[i][5:0]]));
  end

endmodule

// File: rtl/dreq_router.sv
module dreq_router
  import dreq_router_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int NUM_SRC = 64,
  localparam int CPG = NUM_CH / NUM_GROUPS,
  localparam int AW  = (CPG > 1) ? $clog2(CPG) : 1,
  localparam int GW  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [GW-1:0]      cfg_grp,
  input  logic [AW-1:0]      cfg_off,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic [NUM_SRC-1:0] src_req,
  output logic [NUM_CH-1:0]  ch_req
);

  cfg_byte_t [NUM_GROUPS-1:0]         grp_rdata;
  logic      [NUM_GROUPS-1:0]         grp_wr;
  logic      [NUM_GROUPS-1:0][CPG-1:0][7:0] grp_cfg;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_wr[g] = cfg_wr && (cfg_grp == GW'(g));

    dreq_group #(.CH_PER_GRP(CPG), .NUM_SRC(NUM_SRC)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (grp_wr[g]),
      .addr    (cfg_off),
      .wdata   (cfg_wdata),
      .rdata   (grp_rdata[g]),
      .src_req (src_req),
      .ch_req  (ch_req[g*CPG +: CPG]),
      .cfg_q   (grp_cfg[g])
    );

    // R7: a group not selected by a write keeps all of its bytes
    p_isolate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && (cfg_grp == GW'(g))) |=> $stable(grp_cfg[g]));
  end

  always_comb begin
    cfg_rdata = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (cfg_grp == GW'(g)) cfg_rdata = grp_rdata[g];
    end
  end

  // R5: reserved bit never reads as one
  p_rsvd_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[RSVD_POS]);

  // R8: with the strobe low nothing anywhere moves
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(grp_cfg));

endmodule

// File: tb/tb_dreq_router.sv
`timescale 1ns/1ps
module tb_dreq_router;
  localparam int NCH = 32;
  localparam int NSRC = 64;
  localparam int CPG = NCH / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [0:0] cfg_grp = '0;
  logic [3:0] cfg_off = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [NSRC-1:0] src_req = '0;
  logic [NCH-1:0] ch_req;

  int errors = 0;
  int checks = 0;
  logic [7:0] mdl [NCH];

  always #10 clk = ~clk;

  dreq_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_grp(cfg_grp),
    .cfg_off(cfg_off), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .src_req(src_req), .ch_req(ch_req)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] model_req();
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) r[c] = mdl[c][7] & src_req[mdl[c][5:0]];
    return r;
  endfunction

  task automatic wr(input int g, input int o, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_grp = 1'(g); cfg_off = 4'(o); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = 8'h5A;
    mdl[g*CPG + o] = {d[7], 1'b0, d[5:0]};
  endtask

  task automatic rd(input int g, input int o, output logic [7:0] d);
    cfg_grp = 1'(g); cfg_off = 4'(o);
    #1 d = cfg_rdata;
  endtask

  task automatic chk_out(input string tag);
    #1 chk(ch_req === model_req(), tag, 64'(ch_req), 64'(model_req()));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    src_req = '1;
    repeat (3) @(negedge clk);
    chk(ch_req === '0, "R1 outputs in reset", 64'(ch_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ch_req === '0, "R1 outputs after reset", 64'(ch_req), 0);
    for (int c = 0; c < NCH; c++) begin
      rd(c / CPG, c % CPG, d);
      chk(d === 8'h00, "R1 byte after reset", 64'(d), 0);
    end
  endtask

  task automatic t_route();
    logic [7:0] d;
    src_req = '0;
    src_req[17] = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_grp = 1'b0; cfg_off = 4'd5; cfg_wdata = 8'h91;
    #1 chk(ch_req[5] === 1'b0, "R2 not in write cycle", 64'(ch_req[5]), 0);
    @(negedge clk);
    cfg_wr = 1'b0;
    mdl[5] = 8'h91;
    chk_out("R2 follows line 17");
    chk(ch_req[5] === 1'b1, "R2 channel 5 high", 64'(ch_req[5]), 1);
    src_req[17] = 1'b0;
    chk_out("R2 follows line 17 low");
    rd(0, 5, d);
    chk(d === 8'h91, "R6 readback", 64'(d), 64'h91);
  endtask

  task automatic t_disabled();
    wr(1, 3, 8'h2A);
    src_req = '1;
    chk_out("R3 disabled with all lines high");
    chk(ch_req[19] === 1'b0, "R3 channel 19 low", 64'(ch_req[19]), 0);
  endtask

  task automatic t_zero();
    logic [7:0] d;
    src_req = '1;
    wr(0, 5, 8'h00);
    chk(ch_req[5] === 1'b0, "R4 disabled by zero", 64'(ch_req[5]), 0);
    rd(0, 5, d);
    chk(d === 8'h00, "R4 readback zero", 64'(d), 0);
  endtask

  task automatic t_rsvd();
    logic [7:0] d;
    wr(1, 0, 8'hC7);
    rd(1, 0, d);
    chk(d === 8'h87, "R5 reserved bit dropped", 64'(d), 64'h87);
    src_req = '0; src_req[7] = 1'b1;
    chk_out("R5 route with reserved set");
    wr(1, 0, 8'h40);
    rd(1, 0, d);
    chk(d === 8'h00, "R5 reserved only", 64'(d), 0);
    chk_out("R5 no enable from reserved");
  endtask

  task automatic t_walk();
    logic [7:0] d;
    for (int c = 0; c < NCH; c++) wr(c / CPG, c % CPG, 8'(8'h80 | ((c * 7 + 3) % 64)));
    for (int c = 0; c < NCH; c++) begin
      rd(c / CPG, c % CPG, d);
      chk(d === mdl[c], "R7 per-channel readback", 64'(d), 64'(mdl[c]));
    end
    for (int p = 0; p < 6; p++) begin
      src_req = {$urandom, $urandom};
      chk_out("R7 routing pattern");
    end
    src_req = 64'hAAAA_AAAA_AAAA_AAAA;
    chk_out("R7 alternating lines");
  endtask

  task automatic t_fanout();
    wr(0, 0, 8'h89);
    wr(1, 0, 8'h89);
    wr(1, 15, 8'h89);
    src_req = '0; src_req[9] = 1'b1;
    chk_out("R9 shared line");
    chk(ch_req[0] & ch_req[16] & ch_req[31], "R9 three followers", 64'(ch_req), 64'(model_req()));
  endtask

  task automatic t_hold();
    logic [7:0] d;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cfg_grp = 1'(k); cfg_off = 4'(k * 3); cfg_wdata = 8'(k * 37);
      src_req = ~src_req;
    end
    for (int c = 0; c < NCH; c++) begin
      rd(c / CPG, c % CPG, d);
      chk(d === mdl[c], "R8 held without strobe", 64'(d), 64'(mdl[c]));
    end
    chk_out("R8 routing after idle");
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) mdl[c] = 8'h00;
    t_reset();
    t_route();
    t_disabled();
    t_zero();
    t_rsvd();
    t_walk();
    t_fanout();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule